// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block holds wall-clock time and calendar date as packed BCD bytes and moves them forward by one second on each pulse of a once-per-second tick. A carry passes from seconds to minutes, then hours, then day of month, and from there to month and a two-digit year. A binary weekday counter steps whenever the day of month steps. The hour field is kept in either a 24-hour encoding or a 12-hour encoding with a meridiem bit, chosen by a mode input. Month lengths follow the calendar. February gets a 29th day when the year value is a multiple of four, and year 00 counts as such a year.

Host logic loads any single field through a one-cycle write strobe that carries a field selector and a data byte. All seven fields are driven out continuously so the host can read them back. The block does not convert an hour value that is already stored when the mode input changes. The host is expected to rewrite the hour field after it switches the mode.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, weekday 0, month 0x01 and year 0x00.
- R2: Seconds and minutes are BCD bytes with the tens digit in bits 6:4 and the units digit in bits 3:0. Each counts 0x00 to 0x59. A tick that takes seconds from 0x59 back to 0x00 advances minutes. A minutes wrap from 0x59 to 0x00 advances hours.
- R3: With mode_12h = 0, hours count 0x00 to 0x23 as BCD, with the tens digit in bits 5:4. The step from 0x23 to 0x00 advances the day.
- R4: With mode_12h = 1, bit 5 of hours is PM (1) or AM (0), and bits 4:0 hold the hour 01 to 12 in BCD. The steps are: 0x11 to 0x32 (11 AM to 12 PM), 0x32 to 0x21, 0x31 to 0x12 (11 PM to 12 AM, which advances the day), and 0x12 to 0x01.
- R5: The day of month counts from 0x01. It wraps to 0x01 and advances the month after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months except February.
- R6: In February the day wraps after 0x29 when the year is divisible by four (00, 04, ..., 96) and after 0x28 otherwise.
- R7: Months count 0x01 to 0x12 in BCD. The wrap from 0x12 to 0x01 advances the year. Years count 0x00 to 0x99 in BCD and wrap to 0x00.
- R8: The weekday is a binary value 0 to 6 in bits 2:0. It advances on every day advance and wraps from 6 to 0.
- R9: When wr_en is 1, wr_data is stored into the field named by wr_sel: 0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month, 6 year. Unused high bits are cleared. wr_sel = 7 changes no field.
- R10: A tick in the same cycle as wr_en is discarded. Only the written field changes in that cycle.
- R11: In a cycle with no tick and no write, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| mode_12h | input | 1 | 1 selects the 12-hour encoding, 0 selects 24-hour |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 8 | Write data, packed BCD (weekday is binary) |
| seconds | output | 8 | Seconds, BCD |
| minutes | output | 8 | Minutes, BCD |
| hours | output | 8 | Hours, BCD, in the selected encoding |
| days | output | 8 | Day of month, BCD |
| weekday | output | 8 | Weekday 0 to 6 |
| months | output | 8 | Month, BCD |
| years | output | 8 | Year, BCD |

## Verification
The bench goes after the places where a BCD cascade tends to break:
- **Units-digit carry.** A design that adds in binary turns 0x09 into 0x0A.
- **Cascaded rollover.** A design that carries at the wrong point leaves minutes unchanged at 59 seconds.
- **Month lengths.** A wrong month table ends April on day 31 or September on day 31.
- **Leap years.** A careless leap test treats 10 as a leap year or 00 as not a leap year.
- **12-hour boundaries.** A design that gets these wrong advances the day at noon instead of midnight, or produces 0x13 or 0x00.

The bench also checks that a write in the same cycle as a tick drops that tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FW = 8;            // field width in bits
  localparam int WDAY_LAST = 6;     // last weekday value

  typedef enum logic [2:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DAY   = 3'd3,
    SEL_WDAY  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6,
    SEL_NONE  = 3'd7
  } field_sel_e;

  // add one to a two-digit packed BCD value
  function automatic logic [FW-1:0] bcd_inc(input logic [FW-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // a two-digit BCD year is a multiple of four when:
  //   tens even -> units 0, 4 or 8
  //   tens odd  -> units 2 or 6
  function automatic logic is_leap(input logic [FW-1:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  // last day of a month, as BCD
  function automatic logic [FW-1:0] last_day(input logic [FW-1:0] mon,
                                             input logic [FW-1:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // next hour value; bit 6 of the result is the day carry
  function automatic logic [6:0] hour_next(input logic [5:0] h, input logic m12);
    logic [7:0] t;
    if (!m12) begin
      if (h == 6'h23) return {1'b1, 6'h00};
      t = bcd_inc({2'b00, h});
      return {1'b0, t[5:0]};
    end
    if (h[4:0] == 5'h11) return {h[5], ~h[5], 5'h12};
    if (h[4:0] == 5'h12) return {1'b0, h[5], 5'h01};
    t = bcd_inc({3'b000, h[4:0]});
    return {1'b0, h[5], t[4:0]};
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
#(
  parameter logic [FW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_val,
  input  logic          step,
  input  logic [FW-1:0] lo,
  input  logic [FW-1:0] hi,
  output logic [FW-1:0] value,
  output logic          wrap
);
  logic at_top;

  // ">=" so that a value loaded past the limit still wraps
  assign at_top = (value >= hi);
  assign wrap   = step && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= RST_VAL;
    else if (load) value <= load_val;
    else if (step) value <= at_top ? lo : bcd_inc(value);
  end
endmodule

// File: rtl/rtc_hour_counter.sv
module rtc_hour_counter
  import rtc_cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_val,
  input  logic          step,
  input  logic          mode_12h,
  output logic [FW-1:0] value,
  output logic          day_carry
);
  logic [6:0] nxt;

  assign nxt       = hour_next(value[5:0], mode_12h);
  assign day_carry = step && nxt[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (step) value <= {2'b00, nxt[5:0]};
  end
endmodule

// File: rtl/rtc_weekday_counter.sv
module rtc_weekday_counter
  import rtc_cal_pkg::*;
#(
  parameter int LAST = WDAY_LAST
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_val,
  input  logic          step,
  output logic [FW-1:0] value
);
  localparam logic [FW-1:0] LAST_V = FW'(LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (step) value <= (value >= LAST_V) ? '0 : value + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode_12h,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] seconds,
  output logic [7:0] minutes,
  output logic [7:0] hours,
  output logic [7:0] days,
  output logic [7:0] weekday,
  output logic [7:0] months,
  output logic [7:0] years
);
  // per-field write strobes and masked write data
  logic [6:0]    ld;
  logic [FW-1:0] ld_val [7];

  always_comb begin
    for (int i = 0; i < 7; i++) ld[i] = wr_en && (wr_sel == 3'(i));
  end

  assign ld_val[SEL_SEC]   = {1'b0, wr_data[6:0]};
  assign ld_val[SEL_MIN]   = {1'b0, wr_data[6:0]};
  assign ld_val[SEL_HOUR]  = {2'b0, wr_data[5:0]};
  assign ld_val[SEL_DAY]   = {2'b0, wr_data[5:0]};
  assign ld_val[SEL_WDAY]  = {5'b0, wr_data[2:0]};
  assign ld_val[SEL_MONTH] = {3'b0, wr_data[4:0]};
  assign ld_val[SEL_YEAR]  = wr_data;

  // cascade events, named for the checker
  logic          sec_step, sec_wrap, min_wrap, hour_carry, day_wrap, mon_wrap;
  logic          yr_wrap;
  logic [FW-1:0] day_hi;
  logic [1:0]    sm_step, sm_wrap;
  logic [FW-1:0] sm_val [2];

  assign sec_step = tick && !wr_en;   // a write drops the tick
  assign sm_step  = {sm_wrap[0], sec_step};
  assign sec_wrap = sm_wrap[0];
  assign min_wrap = sm_wrap[1];
  assign seconds  = sm_val[0];
  assign minutes  = sm_val[1];

  // seconds and minutes share one shape
  for (genvar g = 0; g < 2; g++) begin : g_sm
    rtc_bcd_field #(.RST_VAL(8'h00)) u_fld (
      .clk(clk), .rst_n(rst_n), .load(ld[g]), .load_val(ld_val[g]),
      .step(sm_step[g]), .lo(8'h00), .hi(8'h59),
      .value(sm_val[g]), .wrap(sm_wrap[g])
    );
  end

  rtc_hour_counter u_hour (
    .clk(clk), .rst_n(rst_n), .load(ld[SEL_HOUR]), .load_val(ld_val[SEL_HOUR]),
    .step(min_wrap), .mode_12h(mode_12h), .value(hours), .day_carry(hour_carry)
  );

  assign day_hi = last_day(months, years);

  rtc_bcd_field #(.RST_VAL(8'h01)) u_day (
    .clk(clk), .rst_n(rst_n), .load(ld[SEL_DAY]), .load_val(ld_val[SEL_DAY]),
    .step(hour_carry), .lo(8'h01), .hi(day_hi), .value(days), .wrap(day_wrap)
  );

  rtc_weekday_counter u_wday (
    .clk(clk), .rst_n(rst_n), .load(ld[SEL_WDAY]), .load_val(ld_val[SEL_WDAY]),
    .step(hour_carry), .value(weekday)
  );

  rtc_bcd_field #(.RST_VAL(8'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .load(ld[SEL_MONTH]), .load_val(ld_val[SEL_MONTH]),
    .step(day_wrap), .lo(8'h01), .hi(8'h12), .value(months), .wrap(mon_wrap)
  );

  rtc_bcd_field #(.RST_VAL(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .load(ld[SEL_YEAR]), .load_val(ld_val[SEL_YEAR]),
    .step(mon_wrap), .lo(8'h00), .hi(8'h99), .value(years), .wrap(yr_wrap)
  );

  logic unused_ok;
  assign unused_ok = yr_wrap;
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] seconds,
  input logic [7:0] minutes,
  input logic [7:0] days,
  input logic [7:0] weekday,
  input logic       sec_wrap,
  input logic       day_wrap
);
  // R2: a seconds wrap always moves minutes
  a_r2_min_follows_sec: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> !$stable(minutes));

  // R5: a day-of-month wrap lands on day 01
  a_r5_day_restart: assert property (@(posedge clk) disable iff (!rst_n)
    day_wrap |=> (days == 8'h01));

  // R8: weekday never leaves 0..6
  a_r8_weekday_range: assert property (@(posedge clk) disable iff (!rst_n)
    weekday <= 8'd6);

  // R10: a seconds write wins over a tick in the same cycle
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> (seconds == {1'b0, $past(wr_data[6:0])}));

  // R11: nothing moves without a tick or a write
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> ($stable(seconds) && $stable(minutes) && $stable(days)));
endmodule

bind rtc_calendar_core rtc_calendar_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .seconds(seconds), .minutes(minutes), .days(days),
  .weekday(weekday), .sec_wrap(sec_wrap), .day_wrap(day_wrap)
);

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
  logic       clk = 0, rst_n = 0, tick = 0, mode_12h = 0, wr_en = 0;
  logic [2:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] seconds, minutes, hours, days, weekday, months, years;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_calendar_core dut (.*);

  typedef struct packed {
    logic       m12;
    logic [7:0] s, mi, h, d, w, mo, y;     // preset
    logic [7:0] es, emi, eh, ed, ew, emo, ey; // after one tick
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h10,8'h20,8'h05,8'h15,8'd2,8'h03,8'h24, 8'h11,8'h20,8'h05,8'h15,8'd2,8'h03,8'h24}, // R2 plain
    '{1'b0, 8'h09,8'h20,8'h05,8'h15,8'd2,8'h03,8'h24, 8'h10,8'h20,8'h05,8'h15,8'd2,8'h03,8'h24}, // R2 units carry
    '{1'b0, 8'h59,8'h14,8'h05,8'h15,8'd2,8'h03,8'h24, 8'h00,8'h15,8'h05,8'h15,8'd2,8'h03,8'h24}, // R2 minute carry
    '{1'b0, 8'h59,8'h59,8'h09,8'h15,8'd2,8'h03,8'h24, 8'h00,8'h00,8'h10,8'h15,8'd2,8'h03,8'h24}, // R3 hour units
    '{1'b0, 8'h59,8'h59,8'h23,8'h15,8'd6,8'h05,8'h24, 8'h00,8'h00,8'h00,8'h16,8'd0,8'h05,8'h24}, // R3 R8 midnight
    '{1'b0, 8'h59,8'h59,8'h23,8'h30,8'd3,8'h04,8'h24, 8'h00,8'h00,8'h00,8'h01,8'd4,8'h05,8'h24}, // R5 April
    '{1'b0, 8'h59,8'h59,8'h23,8'h30,8'd3,8'h01,8'h24, 8'h00,8'h00,8'h00,8'h31,8'd4,8'h01,8'h24}, // R5 January 30
    '{1'b0, 8'h59,8'h59,8'h23,8'h30,8'd3,8'h09,8'h24, 8'h00,8'h00,8'h00,8'h01,8'd4,8'h10,8'h24}, // R5 R7 September
    '{1'b0, 8'h59,8'h59,8'h23,8'h30,8'd3,8'h11,8'h24, 8'h00,8'h00,8'h00,8'h01,8'd4,8'h12,8'h24}, // R5 November
    '{1'b0, 8'h59,8'h59,8'h23,8'h31,8'd3,8'h08,8'h24, 8'h00,8'h00,8'h00,8'h01,8'd4,8'h09,8'h24}, // R5 August 31
    '{1'b0, 8'h59,8'h59,8'h23,8'h28,8'd1,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h01,8'd2,8'h03,8'h23}, // R6 non-leap
    '{1'b0, 8'h59,8'h59,8'h23,8'h28,8'd1,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h29,8'd2,8'h02,8'h24}, // R6 leap 24
    '{1'b0, 8'h59,8'h59,8'h23,8'h28,8'd1,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h29,8'd2,8'h02,8'h00}, // R6 year 00 leap
    '{1'b0, 8'h59,8'h59,8'h23,8'h29,8'd1,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h01,8'd2,8'h03,8'h00}, // R6 Feb 29 end
    '{1'b0, 8'h59,8'h59,8'h23,8'h28,8'd1,8'h02,8'h10, 8'h00,8'h00,8'h00,8'h01,8'd2,8'h03,8'h10}, // R6 year 10 not leap
    '{1'b0, 8'h59,8'h59,8'h23,8'h28,8'd1,8'h02,8'h12, 8'h00,8'h00,8'h00,8'h29,8'd2,8'h02,8'h12}, // R6 year 12 leap
    '{1'b0, 8'h59,8'h59,8'h23,8'h31,8'd5,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'd6,8'h01,8'h00}, // R7 century wrap
    '{1'b0, 8'h59,8'h59,8'h23,8'h31,8'd5,8'h12,8'h45, 8'h00,8'h00,8'h00,8'h01,8'd6,8'h01,8'h46}, // R7 year step
    '{1'b1, 8'h59,8'h59,8'h11,8'h15,8'd2,8'h03,8'h24, 8'h00,8'h00,8'h32,8'h15,8'd2,8'h03,8'h24}, // R4 11AM->12PM
    '{1'b1, 8'h59,8'h59,8'h32,8'h15,8'd2,8'h03,8'h24, 8'h00,8'h00,8'h21,8'h15,8'd2,8'h03,8'h24}, // R4 12PM->1PM
    '{1'b1, 8'h59,8'h59,8'h31,8'h15,8'd2,8'h03,8'h24, 8'h00,8'h00,8'h12,8'h16,8'd3,8'h03,8'h24}, // R4 11PM->12AM
    '{1'b1, 8'h59,8'h59,8'h12,8'h15,8'd2,8'h03,8'h24, 8'h00,8'h00,8'h01,8'h15,8'd2,8'h03,8'h24}  // R4 12AM->1AM
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_field(input logic [2:0] sel, input logic [7:0] val);
    wr_en = 1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic check_all(input string tag, input logic [7:0] s, mi, h, d, w, mo, y);
    chk({tag, " seconds"}, seconds, s);
    chk({tag, " minutes"}, minutes, mi);
    chk({tag, " hours"},   hours,   h);
    chk({tag, " days"},    days,    d);
    chk({tag, " weekday"}, weekday, w);
    chk({tag, " months"},  months,  mo);
    chk({tag, " years"},   years,   y);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_all("R1 reset", 8'h00, 8'h00, 8'h00, 8'h01, 8'd0, 8'h01, 8'h00);

    // table walk: preset fields, one tick, compare
    for (int i = 0; i < NV; i++) begin
      mode_12h = VECS[i].m12;
      write_field(3'd0, VECS[i].s);
      write_field(3'd1, VECS[i].mi);
      write_field(3'd2, VECS[i].h);
      write_field(3'd5, VECS[i].mo);
      write_field(3'd6, VECS[i].y);
      write_field(3'd3, VECS[i].d);
      write_field(3'd4, VECS[i].w);
      tick = 1;
      @(negedge clk);
      tick = 0;
      check_all($sformatf("vector %0d", i), VECS[i].es, VECS[i].emi, VECS[i].eh,
                VECS[i].ed, VECS[i].ew, VECS[i].emo, VECS[i].ey);
    end

    // R9: write masking and the unused selector
    mode_12h = 0;
    write_field(3'd0, 8'hC5);
    chk("R9 seconds mask", seconds, 8'h45);
    write_field(3'd4, 8'hFB);
    chk("R9 weekday mask", weekday, 8'd3);
    write_field(3'd7, 8'h55);
    check_all("R9 selector 7 ignored", 8'h45, 8'h00, 8'h01, 8'h15, 8'd3, 8'h03, 8'h24);

    // R10: a write with a tick in the same cycle drops the tick
    write_field(3'd0, 8'h59);
    wr_en = 1; wr_sel = 3'd0; wr_data = 8'h30; tick = 1;
    @(negedge clk);
    wr_en = 0; tick = 0;
    chk("R10 written seconds", seconds, 8'h30);
    chk("R10 minutes untouched", minutes, 8'h00);
    wr_en = 1; wr_sel = 3'd1; wr_data = 8'h07; tick = 1;
    @(negedge clk);
    wr_en = 0; tick = 0;
    chk("R10 seconds not ticked", seconds, 8'h30);
    chk("R10 minutes written", minutes, 8'h07);

    // R11: idle cycles change nothing
    repeat (5) @(negedge clk);
    check_all("R11 idle", 8'h30, 8'h07, 8'h01, 8'h15, 8'd3, 8'h03, 8'h24);

    // R2 R3: a run of ticks across a minute boundary
    write_field(3'd0, 8'h55);
    for (int k = 0; k < 7; k++) begin
      tick = 1;
      @(negedge clk);
      tick = 0;
      @(negedge clk);
    end
    chk("R2 run seconds", seconds, 8'h02);
    chk("R2 run minutes", minutes, 8'h08);

    finish_run();
  end
endmodule